// File: doc/BRIEF.md
# Line-Chunked Auxiliary Memory DMA Engine

This block copies data between a main memory and an auxiliary memory, one 32-byte line at a time. Software loads a main byte address, an auxiliary byte address, and then a byte count with a direction flag. Writing the count starts the copy. The engine splits the job into bursts of no more than 16 lines. Each burst is held open for a fixed 246 cycles per line it carries. When a burst ends, the engine either starts the next one or, if nothing is left, finishes.

Auxiliary addresses are logical. First they are folded into a 64 MB window and aligned to a line. A three-bit size code then maps them onto physical storage. A line that falls past the configured capacity is not an error: a copy into main memory delivers zeros for it, and a copy into auxiliary memory drops it. In both cases the addresses still step forward.

At the end of a job the busy flag drops, a one-cycle interrupt pulse is issued, and a sticky status bit is set. Both memories are simple synchronous ports, one line wide. A read strobe in one cycle returns its data in the next cycle.

Top module: `aux_dma_engine`

## Requirements
- R1: A write with `reg_sel`=2 while idle loads the byte count from `reg_wdata[23:0]` and the direction from `reg_wdata[31]`. If the line count `reg_wdata[23:5]` is nonzero, `busy` is high from the next cycle. `reg_sel`=0 loads the main address and `reg_sel`=1 loads the auxiliary address, both as byte addresses.
- R2: Each line moved advances the main line address and the auxiliary line address by one (32 bytes) and lowers the remaining line count by one. Bits [4:0] of addresses and count are ignored.
- R3: A job is split into bursts of at most 16 lines, and a burst of n lines lasts n×246 cycles. For a job of L lines, `irq` is high in exactly the cycle that follows L×246 clock edges after the count-write edge.
- R4: Direction 0 reads main memory and writes auxiliary memory. Direction 1 reads auxiliary memory and writes main memory. Write data is the line returned one cycle after the read strobe.
- R5: Before mapping, the auxiliary address is ANDed with 0x3FFFFE0, so bits above 25 and bits [4:0] have no effect.
- R6: `size_code` selects the capacity: 0 is 2 MB, 1 is 4 MB, 2 is 8 MB, 3 is 16 MB, and 4 to 7 are 32 MB. A masked address at or above the capacity is out of range.
- R7: Physical byte address `ax_line`×32 is computed as follows. For codes 0 to 2 it is ((a & 0xFFFFFE00)<<1)|(a & 0x1FF). For code 3 it is a. For codes 4 to 7 it is ((a & 0xFF800000)>>1)|(a & 0x3FFFFF).
- R8: An out-of-range line in direction 1 issues no auxiliary read and writes an all-zero line to main memory.
- R9: An out-of-range line in direction 0 still reads main memory but issues no auxiliary write. Both addresses still advance.
- R10: At completion `busy` falls, `irq` is high for one cycle, and `irq_status` is set.
- R11: A write with `reg_sel`=3 and `reg_wdata[0]`=1 clears `irq_status`. With bit 0 = 0 it has no effect.
- R12: Writes with `reg_sel` 0, 1 or 2 while `busy` is high are ignored.
- R13: A count write whose line count is zero raises `irq` in the next cycle, never raises `busy`, and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 main addr, 1 aux addr, 2 count/direction, 3 status clear |
| reg_wdata | input | 32 | Register write data |
| size_code | input | 3 | Auxiliary capacity code |
| busy | output | 1 | Job in progress |
| irq | output | 1 | One-cycle completion pulse |
| irq_status | output | 1 | Sticky completion flag |
| mm_rd | output | 1 | Main memory read strobe |
| mm_wr | output | 1 | Main memory write strobe |
| mm_line | output | 21 | Main memory line address |
| mm_wdata | output | 256 | Main memory write line |
| mm_rdata | input | 256 | Main memory read line (one cycle after `mm_rd`) |
| ax_rd | output | 1 | Auxiliary memory read strobe |
| ax_wr | output | 1 | Auxiliary memory write strobe |
| ax_line | output | 19 | Auxiliary physical line address |
| ax_wdata | output | 256 | Auxiliary memory write line |
| ax_rdata | input | 256 | Auxiliary memory read line (one cycle after `ax_rd`) |

## Verification
A table of single-line jobs covers every size code, both directions, a mirrored high address, an unaligned address, and addresses exactly at capacity. Together these separate the three mapping formulas and the range test from one another. A 20-line job crosses a burst boundary, which shows whether the burst cap and the pacing are right. During that job the registers are rewritten to show that the writes are ignored. Two-line jobs that step from the last in-range line to the first out-of-range line separate zero-fill from dropped writes, and show that the addresses keep advancing. A zero count and the status clear are checked at the ports.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;

  localparam int LINE_SHIFT = 5;
  localparam int AUX_LA_W   = 26;
  localparam int AUX_PA_W   = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_WAIT} dma_state_e;

  typedef struct packed {
    logic                hit;
    logic [AUX_PA_W-1:0] phys;
  } aux_map_t;

  // Fold a logical auxiliary byte address into the 64 MB window and map it
  // to physical storage for the given capacity code.
  function automatic aux_map_t map_aux(input logic [AUX_LA_W-1:0] la,
                                       input logic [2:0] code);
    aux_map_t            r;
    logic [AUX_LA_W-1:0] m;
    logic [AUX_LA_W-1:0] p;
    logic [AUX_LA_W:0]   cap;
    m = la & 26'h3FF_FFE0;
    if (code[2]) cap = 27'h200_0000;
    else         cap = 27'h020_0000 << code[1:0];
    if (code[2])                p = ((m & 26'h380_0000) >> 1) | (m & 26'h03F_FFFF);
    else if (code[1:0] == 2'b11) p = m;
    else                        p = ((m & 26'h3FF_FE00) << 1) | (m & 26'h000_01FF);
    r.hit  = ({1'b0, m} < cap);
    r.phys = p[AUX_PA_W-1:0];
    return r;
  endfunction

  function automatic int unsigned burst_len(input int unsigned left,
                                            input int unsigned cap);
    return (left > cap) ? cap : left;
  endfunction

  function automatic int unsigned pace_ticks(input int unsigned lines,
                                             input int unsigned per_line);
    return lines * per_line;
  endfunction

endpackage

// File: rtl/aux_dma_regs.sv
module aux_dma_regs #(
  parameter  int MAIN_AW = 26,
  parameter  int CNT_W   = 24,
  localparam int ML_W    = MAIN_AW - 5,
  localparam int LL_W    = CNT_W - 5,
  localparam int AL_W    = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_main,
  input  logic            ld_aux,
  input  logic            ld_cnt,
  input  logic [31:0]     wdata,
  input  logic            busy,
  input  logic            step,
  output logic [ML_W-1:0] cur_main,
  output logic [AL_W-1:0] cur_aux,
  output logic [LL_W-1:0] lines_left,
  output logic            dir
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_main   <= '0;
      cur_aux    <= '0;
      lines_left <= '0;
      dir        <= 1'b0;
    end else if (step) begin
      cur_main   <= cur_main + 1'b1;
      cur_aux    <= cur_aux + 1'b1;
      lines_left <= lines_left - 1'b1;
    end else begin
      if (ld_main) cur_main <= wdata[MAIN_AW-1:5];
      if (ld_aux)  cur_aux  <= wdata[25:5];
      if (ld_cnt) begin
        lines_left <= wdata[CNT_W-1:5];
        dir        <= wdata[31];
      end
    end
  end

  // R2: every moved line takes one off the count and moves both pointers
  p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (lines_left == $past(lines_left) - 1'b1) &&
             (cur_aux == $past(cur_aux) + 1'b1));

  // R12: while a job runs only line steps may change the registers
  p_hold_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(cur_main) && $stable(cur_aux) && $stable(dir)));

endmodule

// File: rtl/aux_dma_pacer.sv
module aux_dma_pacer import aux_dma_pkg::*; #(
  parameter  int TICKS     = 246,
  parameter  int BURST_MAX = 16,
  parameter  int LL_W      = 19,
  localparam int BL_W      = $clog2(BURST_MAX + 1),
  localparam int TW        = $clog2(BURST_MAX * TICKS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LL_W-1:0] lines_in,
  input  logic            step,
  output logic [BL_W-1:0] burst_left,
  output logic            expired
);

  int unsigned   blen;
  logic [TW-1:0] timer;

  always_comb blen = burst_len(32'(lines_in), BURST_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer      <= '0;
      burst_left <= '0;
    end else if (load) begin
      burst_left <= BL_W'(blen);
      timer      <= TW'(pace_ticks(blen, TICKS) - 1);
    end else begin
      if (timer != '0) timer <= timer - 1'b1;
      if (step && burst_left != '0) burst_left <= burst_left - 1'b1;
    end
  end

  assign expired = (timer == '0);

  // R3: a started burst holds between one and BURST_MAX lines and a running window
  p_burst_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_left != '0) && (burst_left <= BL_W'(BURST_MAX)) && !expired);

endmodule

// File: rtl/aux_dma_engine.sv
module aux_dma_engine import aux_dma_pkg::*; #(
  parameter  int MAIN_AW        = 26,
  parameter  int CNT_W          = 24,
  parameter  int LINE_W         = 256,
  parameter  int TICKS_PER_LINE = 246,
  parameter  int BURST_MAX      = 16,
  localparam int ML_W           = MAIN_AW - LINE_SHIFT,
  localparam int LL_W           = CNT_W - LINE_SHIFT,
  localparam int AL_W           = AUX_LA_W - LINE_SHIFT,
  localparam int PL_W           = AUX_PA_W - LINE_SHIFT,
  localparam int BL_W           = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        size_code,
  output logic              busy,
  output logic              irq,
  output logic              irq_status,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [ML_W-1:0]   mm_line,
  output logic [LINE_W-1:0] mm_wdata,
  input  logic [LINE_W-1:0] mm_rdata,
  output logic              ax_rd,
  output logic              ax_wr,
  output logic [PL_W-1:0]   ax_line,
  output logic [LINE_W-1:0] ax_wdata,
  input  logic [LINE_W-1:0] ax_rdata
);

  dma_state_e      state, nxt;
  logic            wr_ok, ld_main, ld_aux, ld_cnt, kick, zero_kick;
  logic            step, pace_load, expired, done_evt, dir;
  logic [LL_W-1:0] cnt_in, lines_left, pace_lines;
  logic [ML_W-1:0] cur_main;
  logic [AL_W-1:0] cur_aux;
  logic [BL_W-1:0] burst_left;
  aux_map_t        amap;

  assign busy      = (state != ST_IDLE);
  assign wr_ok     = reg_wr && !busy;
  assign ld_main   = wr_ok && (reg_sel == 2'd0);
  assign ld_aux    = wr_ok && (reg_sel == 2'd1);
  assign ld_cnt    = wr_ok && (reg_sel == 2'd2);
  assign cnt_in    = reg_wdata[CNT_W-1:LINE_SHIFT];
  assign kick      = ld_cnt && (cnt_in != '0);
  assign zero_kick = ld_cnt && (cnt_in == '0);
  assign step      = (state == ST_WR);
  assign done_evt  = (state == ST_WAIT) && expired && (lines_left == '0);
  assign pace_load = kick || ((state == ST_WAIT) && expired && (lines_left != '0));
  assign pace_lines = (state == ST_IDLE) ? cnt_in : lines_left;

  aux_dma_regs #(.MAIN_AW(MAIN_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_main(ld_main), .ld_aux(ld_aux), .ld_cnt(ld_cnt),
    .wdata(reg_wdata), .busy(busy), .step(step), .cur_main(cur_main),
    .cur_aux(cur_aux), .lines_left(lines_left), .dir(dir)
  );

  aux_dma_pacer #(.TICKS(TICKS_PER_LINE), .BURST_MAX(BURST_MAX), .LL_W(LL_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(pace_load), .lines_in(pace_lines),
    .step(step), .burst_left(burst_left), .expired(expired)
  );

  always_comb amap = map_aux({cur_aux, {LINE_SHIFT{1'b0}}}, size_code);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (kick) nxt = ST_RD;
      ST_RD:   nxt = ST_WR;
      ST_WR:   nxt = (burst_left == BL_W'(1)) ? ST_WAIT : ST_RD;
      ST_WAIT: if (expired) nxt = (lines_left != '0) ? ST_RD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      irq        <= 1'b0;
      irq_status <= 1'b0;
    end else begin
      state <= nxt;
      irq   <= done_evt || zero_kick;
      if (done_evt || zero_kick)
        irq_status <= 1'b1;
      else if (reg_wr && reg_sel == 2'd3 && reg_wdata[0])
        irq_status <= 1'b0;
    end
  end

  assign mm_rd    = (state == ST_RD) && !dir;
  assign ax_rd    = (state == ST_RD) && dir && amap.hit;
  assign ax_wr    = (state == ST_WR) && !dir && amap.hit;
  assign mm_wr    = (state == ST_WR) && dir;
  assign mm_line  = cur_main;
  assign ax_line  = amap.phys[AUX_PA_W-1:LINE_SHIFT];
  assign ax_wdata = mm_rdata;
  assign mm_wdata = amap.hit ? ax_rdata : '0;

  // R4: at most one memory strobe per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mm_rd, mm_wr, ax_rd, ax_wr}));

  // R13: no memory traffic while idle
  p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mm_rd || mm_wr || ax_rd || ax_wr));

  // R1: an accepted nonzero count starts a job
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && !busy && reg_wdata[CNT_W-1:LINE_SHIFT] != '0) |=> busy);

  // R3: the pacing window never closes before the burst reaches its wait
  p_wait_at_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && expired) |-> (state == ST_WAIT));

  // R10: the completion pulse only appears when idle, with the sticky bit set
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && irq_status));

endmodule

// File: tb/test_aux_dma_engine.sv
module test_aux_dma_engine;

  localparam int T = 246;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic [31:0]  reg_wdata = '0;
  logic [2:0]   size_code = 3'd3;
  logic         busy, irq, irq_status;
  logic         mm_rd, mm_wr, ax_rd, ax_wr;
  logic [20:0]  mm_line;
  logic [18:0]  ax_line;
  logic [255:0] mm_wdata, ax_wdata;
  logic [255:0] mm_rdata = '0;
  logic [255:0] ax_rdata = '0;

  aux_dma_engine i_aux_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .size_code(size_code), .busy(busy), .irq(irq),
    .irq_status(irq_status), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_line(mm_line),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .ax_rd(ax_rd), .ax_wr(ax_wr),
    .ax_line(ax_line), .ax_wdata(ax_wdata), .ax_rdata(ax_rdata)
  );

  always #2.5 clk = ~clk;

  function automatic logic [255:0] mpat(input logic [20:0] l);
    return {8{32'hC0DE_0000 ^ {11'd0, l}}};
  endfunction
  function automatic logic [255:0] apat(input logic [18:0] l);
    return {8{32'h5A5A_0000 ^ {13'd0, l}}};
  endfunction

  int           cyc = 0;
  int           n_mrd = 0, n_mwr = 0, n_ard = 0, n_awr = 0;
  logic [20:0]  last_mrd = '0, last_mwr = '0;
  logic [18:0]  last_ard = '0, last_awr = '0;
  logic [255:0] last_mwdata = '0, last_awdata = '0;
  int           n_chk = 0, n_fail = 0;

  // memory models and port monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mm_rd) begin n_mrd <= n_mrd + 1; last_mrd <= mm_line; mm_rdata <= mpat(mm_line); end
    if (mm_wr) begin n_mwr <= n_mwr + 1; last_mwr <= mm_line; last_mwdata <= mm_wdata; end
    if (ax_rd) begin n_ard <= n_ard + 1; last_ard <= ax_line; ax_rdata <= apat(ax_line); end
    if (ax_wr) begin n_awr <= n_awr + 1; last_awr <= ax_line; last_awdata <= ax_wdata; end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  function automatic logic [31:0] cnt_word(input logic d, input int lines);
    return {d, 6'd0, 25'(lines * 32)};
  endfunction

  // start a job of given lines, check timing and completion
  task automatic xfer(input logic d, input int lines);
    int t0;
    do_write(2'd2, cnt_word(d, lines));
    t0 = cyc;
    chk("R1 busy after start", busy, 1'b1);
    wait_to(t0 + lines * T - 1);
    chk("R3 not yet done", {irq, busy}, 2'b01);
    wait_to(t0 + lines * T);
    chk("R3 R10 completion", {irq, busy, irq_status}, 3'b101);
    wait_to(t0 + lines * T + 1);
    chk("R10 irq one cycle", irq, 1'b0);
  endtask

  // code, dir, aux address, in-range, physical line
  localparam int NV = 10;
  localparam logic [55:0] VECS [0:NV-1] = '{
    {3'd3, 1'b0, 32'h0012_3440, 1'b1, 19'h091A2},
    {3'd0, 1'b1, 32'h0001_2A60, 1'b1, 19'h012A3},
    {3'd1, 1'b0, 32'h003F_0000, 1'b1, 19'h3F000},
    {3'd2, 1'b1, 32'h0041_2340, 1'b1, 19'h4122A},
    {3'd4, 1'b0, 32'h01C0_0020, 1'b1, 19'h60001},
    {3'd7, 1'b1, 32'h0500_0040, 1'b1, 19'h40002},
    {3'd0, 1'b1, 32'h0020_0000, 1'b0, 19'h00000},
    {3'd3, 1'b0, 32'h0000_001F, 1'b1, 19'h00000},
    {3'd1, 1'b0, 32'h0040_0000, 1'b0, 19'h00000},
    {3'd2, 1'b0, 32'h0081_2340, 1'b0, 19'h00000}
  };

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    finish_run();
  end

  initial begin
    int b_mrd, b_mwr, b_ard, b_awr, t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10 R1)
    chk("R1 R10 reset outputs", {busy, irq, irq_status}, 3'b000);
    chk("R13 reset no strobes", n_mrd + n_mwr + n_ard + n_awr, 0);

    // R13: zero count
    b_mrd = n_mrd; b_mwr = n_mwr; b_ard = n_ard; b_awr = n_awr;
    do_write(2'd2, cnt_word(1'b0, 0));
    chk("R13 zero count irq next cycle", {irq, busy, irq_status}, 3'b101);
    repeat (3) @(negedge clk);
    chk("R13 zero count no access",
        (n_mrd - b_mrd) + (n_mwr - b_mwr) + (n_ard - b_ard) + (n_awr - b_awr), 0);
    chk("R10 pulse gone", {irq, busy}, 2'b00);

    // R11: status clear
    do_write(2'd3, 32'h0);
    chk("R11 write of zero keeps status", irq_status, 1'b1);
    do_write(2'd3, 32'h1);
    chk("R11 W1C clears status", irq_status, 1'b0);

    // mapping and direction table
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  code;
      logic        d, hit;
      logic [31:0] aadr;
      logic [18:0] pl;
      logic [20:0] ml;
      {code, d, aadr, hit, pl} = VECS[i];
      ml = 21'h8000 + 21'(2 * i);
      size_code = code;
      do_write(2'd0, {ml, 5'd0} | 32'h0);
      do_write(2'd1, aadr);
      b_mrd = n_mrd; b_mwr = n_mwr; b_ard = n_ard; b_awr = n_awr;
      xfer(d, 1);
      if (!d) begin
        chk("R4 main read count", n_mrd - b_mrd, 1);
        chk("R5 R6 R9 aux write count", n_awr - b_awr, hit ? 1 : 0);
        if (hit) begin
          chk("R5 R7 aux physical line", last_awr, pl);
          chk("R4 aux write data", last_awdata, mpat(ml));
        end
      end else begin
        chk("R6 R8 aux read count", n_ard - b_ard, hit ? 1 : 0);
        chk("R4 main write line", {n_mwr - b_mwr, 11'd0, last_mwr}, {32'd1, 11'd0, ml});
        if (hit) begin
          chk("R5 R7 aux read line", last_ard, pl);
          chk("R4 main write data", last_mwdata, apat(pl));
        end else
          chk("R8 zero fill", last_mwdata, 256'd0);
      end
    end

    // 20 lines across a burst boundary with writes while busy
    size_code = 3'd3;
    do_write(2'd0, 32'h0020_0000);
    do_write(2'd1, 32'h0010_0000);
    b_mrd = n_mrd; b_awr = n_awr;
    do_write(2'd2, cnt_word(1'b0, 20));
    t0 = cyc;
    wait_to(t0 + 50);
    do_write(2'd0, 32'h0);
    do_write(2'd1, 32'h0);
    do_write(2'd2, cnt_word(1'b1, 1));
    do_write(2'd2, cnt_word(1'b0, 0));
    wait_to(t0 + 16 * T);
    chk("R3 first burst capped at 16", n_awr - b_awr, 16);
    wait_to(t0 + 20 * T - 1);
    chk("R3 R12 no early irq", {irq, busy}, 2'b01);
    wait_to(t0 + 20 * T);
    chk("R3 R10 completion after 20 lines", {irq, busy, irq_status}, 3'b101);
    chk("R2 aux writes", n_awr - b_awr, 20);
    chk("R2 R12 last aux line", last_awr, 19'h08013);
    chk("R2 R12 last main line", {n_mrd - b_mrd, 11'd0, last_mrd}, {32'd20, 11'd0, 21'h10013});

    // R9: last in-range line then dropped write
    size_code = 3'd1;
    do_write(2'd0, 32'h0030_0000);
    do_write(2'd1, 32'h003F_FFE0);
    b_mrd = n_mrd; b_awr = n_awr;
    xfer(1'b0, 2);
    chk("R9 only in-range write lands", n_awr - b_awr, 1);
    chk("R9 R7 in-range line", last_awr, 19'h3FFEF);
    chk("R9 main still advances", {n_mrd - b_mrd, 11'd0, last_mrd}, {32'd2, 11'd0, 21'h18001});

    // R8: last in-range line then zero fill
    size_code = 3'd0;
    do_write(2'd0, 32'h0030_0000);
    do_write(2'd1, 32'h001F_FFE0);
    b_ard = n_ard; b_mwr = n_mwr;
    xfer(1'b1, 2);
    chk("R8 single aux read", {n_ard - b_ard, 13'd0, last_ard}, {32'd1, 13'd0, 19'h1FFEF});
    chk("R8 main writes advance", {n_mwr - b_mwr, 11'd0, last_mwr}, {32'd2, 11'd0, 21'h18001});
    chk("R8 second line zero", last_mwdata, 256'd0);

    finish_run();
  end

endmodule